// File: doc/BRIEF.md
# Programmable Tick Timer

This block pairs a 32-bit tick counter with a single control word that holds a mode, an interrupt enable, a sticky interrupt pending flag and a match period. A divider turns the system clock into a tick-enable pulse; in the target system it is set so that ticks arrive at 20 MHz, one every 50 ns. While the timer runs, each tick advances the counter by one. When the low period-field bits of the advanced count equal the period field of the control word, a match event occurs.

On a match, the pending flag is set if interrupts are enabled. The selected mode then decides what happens to counting: no action, clear the period field of the count so that the next match is one full period later, halt until software restarts the timer, or keep counting so that the field wraps and matches again after its full range. The interrupt output is high while both pending and enable are set.

Software reaches the block through a one-cycle write strobe with a select bit and a combinational read port with its own select bit. It can load the counter at any time and rewrite the control word, which is also how the pending flag is cleared and how a halted timer is restarted.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, `irq` is low and the timer is halted.
- R2: While running, the counter advances by exactly one on every TICK_DIV-th clock cycle and holds its value on the others.
- R3: A match compares only the low PER_W bits of the advanced count with control bits [PER_W-1:0]; counter bits above them have no effect on it.
- R4: On a match with control bit 29 (enable) set, control bit 28 (pending) becomes 1; `irq` is high exactly when bits 29 and 28 are both 1.
- R5: Pending stays 1 until a control write (`wr_sel`=1) carries 0 in bit 28; clearing bit 29 forces `irq` low and stops new pending events.
- R6: With control bits [31:30] = 01 (restart), a match clears the low PER_W bits of the counter and keeps the upper bits, so the next match comes one period later.
- R7: With bits [31:30] = 10 (one-shot), a match leaves the counter at the matching value and halts it; the value then holds.
- R8: With bits [31:30] = 11 (continuous), a match leaves counting untouched, so the next match comes 2^PER_W ticks later.
- R9: With bits [31:30] = 00 (no action), a running timer keeps counting through matches; the pending flag is still set when enabled.
- R10: A counter write (`wr_en`=1, `wr_sel`=0) loads `wr_data` on the next edge, overriding any tick in that cycle, and counting continues from the loaded value.
- R11: A halted timer stays halted until a control write with nonzero bits [31:30]; it then counts from the first tick after that write.
- R12: Control bits [27:PER_W] always read 0; a control write stores bits [31:28] and [PER_W-1:0] as written. `rd_sel`=0 reads the counter, `rd_sel`=1 the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 counter, 1 control word |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Timer interrupt request (pending and enabled) |

## Verification
The bench builds the block with TICK_DIV = 3 and PER_W = 4. The short divider puts several idle cycles between ticks, so holding between ticks and writes landing on or off a tick are both exercised. The four-bit period field lets a continuous-mode wrap of 16 ticks, and repeated restart and one-shot matches, occur within a few hundred cycles, while counter values with nonzero upper bits show that only the field takes part in the match.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam int REG_W  = 32;
  localparam int MODE_HI = 31;
  localparam int MODE_LO = 30;
  localparam int IE_BIT  = 29;
  localparam int IP_BIT  = 28;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tt_mode_e;

  // mask covering the low w bits of a word
  function automatic logic [REG_W-1:0] low_mask(input int unsigned w);
    if (w >= REG_W) return '1;
    return (REG_W'(1) << w) - REG_W'(1);
  endfunction

  // true when the masked count equals the masked period
  function automatic logic field_hit(input logic [REG_W-1:0] cnt,
                                     input logic [REG_W-1:0] per,
                                     input logic [REG_W-1:0] mask);
    return (cnt & mask) == (per & mask);
  endfunction

  // count with its period field returned to zero
  function automatic logic [REG_W-1:0] clear_field(input logic [REG_W-1:0] cnt,
                                                   input logic [REG_W-1:0] mask);
    return cnt & ~mask;
  endfunction

  // keep only the implemented control bits of a written word
  function automatic logic [REG_W-1:0] sanitize_ctrl(input logic [REG_W-1:0] wd,
                                                     input logic [REG_W-1:0] mask);
    return (wd & 32'hF000_0000) | (wd & mask);
  endfunction

  function automatic tt_mode_e mode_of(input logic [REG_W-1:0] ctrl);
    return tt_mode_e'(ctrl[MODE_HI:MODE_LO]);
  endfunction

endpackage

// File: rtl/tt_tick_gen.sv
module tt_tick_gen #(
  parameter int unsigned TICK_DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + CW'(1);
      end
      assign tick_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int unsigned PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  output logic [REG_W-1:0] cnt_o
);
  localparam logic [REG_W-1:0] PER_MASK = low_mask(PER_W);

  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + REG_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (step_i)     cnt_q <= restart_i ? clear_field(cnt_inc, PER_MASK) : cnt_inc;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tt_pkg::*;
#(
  parameter int unsigned PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             match_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             run_o
);
  localparam logic [REG_W-1:0] PER_MASK = low_mask(PER_W);

  logic [REG_W-1:0] ctrl_q;
  logic             run_q;
  logic [REG_W-1:0] wr_clean;

  assign wr_clean = sanitize_ctrl(wr_data_i, PER_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr_i)                       ctrl_q <= wr_clean;
    else if (match_i && ctrl_q[IE_BIT])  ctrl_q[IP_BIT] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= 1'b0;
    else if (wr_i && (mode_of(wr_clean) != TM_OFF))
      run_q <= 1'b1;
    else if (match_i && (mode_of(ctrl_q) == TM_ONESHOT))
      run_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign run_o  = run_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 5,
  parameter int unsigned PER_W    = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam logic [REG_W-1:0] PER_MASK = low_mask(PER_W);

  // named internal events
  logic             tick;
  logic             run_q;
  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] ctrl_q;
  logic             cnt_wr;
  logic             ctrl_wr;
  logic             step_ev;
  logic             match_ev;
  logic             restart_ev;

  assign cnt_wr     = wr_en && !wr_sel;
  assign ctrl_wr    = wr_en &&  wr_sel;
  assign step_ev    = tick && run_q && !cnt_wr;
  assign match_ev   = step_ev && field_hit(cnt_q + REG_W'(1), ctrl_q, PER_MASK);
  assign restart_ev = match_ev && (mode_of(ctrl_q) == TM_RESTART);

  tt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  tt_counter #(.PER_W(PER_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_ev),
    .restart_i  (restart_ev),
    .load_i     (cnt_wr),
    .load_val_i (wr_data),
    .cnt_o      (cnt_q)
  );

  tt_ctrl_reg #(.PER_W(PER_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ctrl_wr),
    .wr_data_i (wr_data),
    .match_i   (match_ev),
    .ctrl_o    (ctrl_q),
    .run_o     (run_q)
  );

  assign rd_data = rd_sel ? ctrl_q : cnt_q;
  assign irq     = ctrl_q[IP_BIT] && ctrl_q[IE_BIT];
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned PER_W = 28
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        run_q,
  input logic        match_ev,
  input logic [31:0] cnt_q,
  input logic [31:0] ctrl_q,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic        irq
);
  localparam logic [31:0] FMASK = (PER_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << PER_W) - 32'd1);

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q[29] && ctrl_q[28]));

  assert_match_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |-> (tick && run_q));

  assert_pending_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && ctrl_q[29] && !(wr_en && wr_sel)) |=> ctrl_q[28]);

  assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[28] && !(wr_en && wr_sel)) |=> ctrl_q[28]);

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && ctrl_q[31:30] == 2'b01) |=> ((cnt_q & FMASK) == 32'd0));

  assert_oneshot_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && ctrl_q[31:30] == 2'b10 && !(wr_en && wr_sel)) |=> !run_q);

  assert_hold_when_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && !wr_sel)) |=> $stable(cnt_q));

  assert_counter_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (cnt_q == $past(wr_data)));

  assert_unused_bits_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & ~FMASK & 32'h0FFF_FFFF) == 32'd0));
endmodule

bind tick_timer tick_timer_chk #(.PER_W(PER_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .run_q    (run_q),
  .match_ev (match_ev),
  .cnt_q    (cnt_q),
  .ctrl_q   (ctrl_q),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .irq      (irq)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/100ps
module sim_tick_timer;
  localparam int DIV   = 3;
  localparam int PW    = 4;
  localparam int FIELD = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  always #4 clk = ~clk;

  tick_timer #(.TICK_DIV(DIV), .PER_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  int          pc = 0;
  logic [31:0] m_cnt = '0;
  logic [31:0] m_ctl = '0;
  bit          m_run = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pc = 0; m_cnt = '0; m_ctl = '0; m_run = 0;
    end else begin
      bit tk, cw, mw, hit, nrun;
      logic [31:0] nx, ncnt, nctl;
      tk = (pc == DIV - 1);
      pc = tk ? 0 : pc + 1;
      cw = wr_en && !wr_sel;
      mw = wr_en && wr_sel;
      nx = m_cnt + 1;
      hit = tk && m_run && !cw && ((nx % FIELD) == (m_ctl % FIELD));
      ncnt = m_cnt;
      if (cw) ncnt = wr_data;
      else if (tk && m_run) ncnt = (hit && m_ctl[31:30] == 2'b01) ? nx - (nx % FIELD) : nx;
      nctl = m_ctl;
      if (mw) nctl = (wr_data & 32'hF000_0000) + (wr_data % FIELD);
      else if (hit && m_ctl[29]) nctl = m_ctl | 32'h1000_0000;
      nrun = m_run;
      if (mw && wr_data[31:30] != 2'b00) nrun = 1;
      else if (hit && m_ctl[31:30] == 2'b10) nrun = 0;
      m_cnt = ncnt; m_ctl = nctl; m_run = nrun;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      rd_sel = 1'b0; #1;
      check({tag, " counter"}, rd_data, m_cnt);
      rd_sel = 1'b1; #1;
      check({tag, " control"}, rd_data, m_ctl);
      check({tag, " irq"}, {31'd0, irq}, {31'd0, m_ctl[29] & m_ctl[28]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 200000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic s, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    @(negedge clk); #2.5;
    rd_sel = s; #1;
    v = rd_data;
  endtask

  initial begin
    logic [31:0] v, v2;
    idle(2); #2;
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    rd(1'b0, v); check("R1 counter after reset", v, 32'd0);
    rd(1'b1, v); check("R1 control after reset", v, 32'd0);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    // R11: stays halted until a nonzero mode is written
    tag = "R11";
    idle(12);
    rd(1'b0, v); check("R11 halted counter", v, 32'd0);
    wr(1'b1, 32'h6000_0005);          // restart mode, enable, period 5
    tag = "R2";
    idle(9);
    tag = "R6";
    idle(40);
    rd(1'b1, v); check("R4 pending after match", {31'd0, v[28]}, 32'd1);
    check("R4 irq after match", {31'd0, irq}, 32'd1);
    // R5: clear pending, then disable interrupts
    tag = "R5";
    wr(1'b1, 32'h4000_0005);          // restart, no enable
    idle(40);
    check("R5 irq masked", {31'd0, irq}, 32'd0);
    rd(1'b1, v); check("R5 pending cleared", {31'd0, v[28]}, 32'd0);
    // R3 / R8: upper bits set, continuous mode
    tag = "R3";
    wr(1'b0, 32'hABCD_0002);
    wr(1'b1, 32'hE000_0007);          // continuous, enable, period 7
    idle(30);
    tag = "R8";
    rd(1'b1, v); check("R3 match with upper bits set", {31'd0, v[28]}, 32'd1);
    wr(1'b1, 32'hE000_0007);          // clear pending
    idle(160);
    // R10: counter loads, including on tick cycles
    tag = "R10";
    wr(1'b0, 32'h0000_0100);
    idle(1);
    wr(1'b0, 32'h0000_0100);
    idle(2);
    wr(1'b0, 32'h1234_5670);
    idle(7);
    // R7: one-shot
    tag = "R7";
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, 32'hA000_0003);          // one-shot, enable, period 3
    idle(40);
    rd(1'b0, v); check("R7 halted at match value", v, 32'h0000_0003);
    idle(20);
    rd(1'b0, v2); check("R7 value holds", v2, v);
    check("R7 irq after one-shot", {31'd0, irq}, 32'd1);
    // R9: no-action mode while running
    tag = "R9";
    wr(1'b1, 32'hC000_0000);          // restart counting
    wr(1'b1, 32'h2000_0002);          // no action, enable, period 2
    idle(100);
    check("R9 pending still set", {31'd0, irq}, 32'd1);
    rd(1'b0, v); idle(9); rd(1'b0, v2);
    check("R9 counting continues", {31'd0, v2 != v}, 32'd1);
    // R12: unimplemented control bits
    tag = "R12";
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); check("R12 control readback", v & 32'hFFFF_FFF0, 32'hF000_0000);
    idle(60);
    @(negedge clk); #3;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule